// File: doc/BRIEF.md
# Debug-Halt Guarded Status Flags

This block holds a small bank of status flags whose clearing needs two accesses in order. A read of the shared status register arms every flag that is set. A later access to a flag's own data register then clears that flag. Each flag is set by a hardware event, and a set event always wins over a clear in the same cycle.

A debug halt can be raised at any time through a level input. On the first cycle of a halt the block emits a one-cycle entry pulse, which the system treats like a software-interrupt request. While the halt lasts, a software-writable clear-enable bit decides whether register accesses may still clear flags:

- With the bit at 0, the flags are guarded. A debugger can read and write registers freely and no flag and no arming changes.
- With the bit at 1, clearing works as usual, and a flag cleared this way stays cleared after the halt ends.

Arming that took place before the halt is kept through a guarded halt. After the halt, a data access alone completes the clear.

Top module: `brk_flag_guard`

## Requirements
- R1: While reset is active and on the first cycle after it, every flag reads 0, the clear-enable readback reads 0 and the halt-entry pulse is 0.
- R2: A set event on flag i makes flag_o[i] read 1 in the cycle after the clock edge that samples it.
- R3: Outside a halt, a status read (stat_rd_i) while a flag is 1 arms that flag. A later data access (data_acc_i[i]) to an armed flag clears it at that edge. A data access to a flag that is not armed leaves it at 1.
- R4: While halt_i is 1 and clear-enable is 0, status reads and data accesses change no flag and arm no flag.
- R5: A flag armed before a guarded halt stays armed through the halt. After the halt, one data access clears it with no new status read.
- R6: While halt_i is 1 and clear-enable is 1, the two-step clear works as in R3. A flag cleared this way still reads 0 after the halt ends.
- R7: A set event and a data access to the same flag in one cycle leave the flag at 1. The set also discards arming, so a following data access alone does not clear it.
- R8: Writing cfg_wdata_i with cfg_we_i = 1 sets the clear-enable bit at that edge, and cfg_rdata_o shows the written value from the next cycle.
- R9: halt_entry_o is 1 for exactly one cycle, the cycle after the first edge at which halt_i is 1 following a cycle with halt_i at 0.
- R10: A data access to flag i never changes any other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_i | input | 1 | Debug halt state level |
| cfg_we_i | input | 1 | Write strobe for the clear-enable bit |
| cfg_wdata_i | input | 1 | Value written to the clear-enable bit |
| cfg_rdata_o | output | 1 | Clear-enable bit readback |
| set_i | input | NUM_FLAGS | Per-flag set events |
| stat_rd_i | input | 1 | Status register read strobe (first clear step) |
| data_acc_i | input | NUM_FLAGS | Per-flag data register access strobes (second clear step) |
| flag_o | output | NUM_FLAGS | Flag values |
| halt_entry_o | output | 1 | One-cycle pulse on halt entry |

## Verification
The hardest case is a flag armed before the halt and then accessed during a guarded halt. Here the armed state, which no port shows, has to survive untouched and then finish the clear after the halt. The bench sweeps the clear-enable value, whether arming comes before the halt, and whether a status read happens inside the halt. In each combination it first probes during the halt with a data access and then probes again after the halt, so the hidden arming shows up in the flag value. A second flag is set and armed in the same pass but never accessed, which shows that clearing one flag leaves the others alone.

// File: rtl/brk_flag_pkg.sv
package brk_flag_pkg;

  // Halt context seen by every flag cell
  typedef struct packed {
    logic halted;
    logic clr_en;
  } halt_ctx_t;

  // Register accesses may change flag state unless halted with clearing off
  function automatic logic access_allowed(halt_ctx_t ctx);
    return !ctx.halted || ctx.clr_en;
  endfunction

endpackage

// File: rtl/brk_rst_sync.sv
module brk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/brk_halt_ctl.sv
module brk_halt_ctl
  import brk_flag_pkg::*;
(
  input  logic      clk,
  input  logic      rst_s_n,
  input  logic      halt_i,
  input  logic      cfg_we_i,
  input  logic      cfg_wdata_i,
  output logic      clr_en_o,
  output logic      entry_o,
  output halt_ctx_t ctx_o
);
  logic clr_en_q, clr_en_d;
  logic halt_q, halt_d;
  logic entry_q, entry_d;

  always_comb begin
    clr_en_d = clr_en_q;
    if (cfg_we_i) clr_en_d = cfg_wdata_i;
    halt_d  = halt_i;
    entry_d = halt_i && !halt_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      clr_en_q <= 1'b0;
      halt_q   <= 1'b0;
      entry_q  <= 1'b0;
    end else begin
      clr_en_q <= clr_en_d;
      halt_q   <= halt_d;
      entry_q  <= entry_d;
    end
  end

  assign clr_en_o     = clr_en_q;
  assign entry_o      = entry_q;
  assign ctx_o.halted = halt_i;
  assign ctx_o.clr_en = clr_en_q;
endmodule

// File: rtl/brk_flag_cell.sv
module brk_flag_cell
  import brk_flag_pkg::*;
(
  input  logic      clk,
  input  logic      rst_s_n,
  input  halt_ctx_t ctx_i,
  input  logic      set_i,
  input  logic      stat_rd_i,
  input  logic      data_acc_i,
  output logic      flag_o,
  output logic      armed_o
);
  logic flag_q, flag_d;
  logic armed_q, armed_d;
  logic allow;

  always_comb begin
    allow   = access_allowed(ctx_i);
    flag_d  = flag_q;
    armed_d = armed_q;
    if (set_i) begin
      flag_d  = 1'b1;
      armed_d = 1'b0;
    end else if (allow) begin
      if (data_acc_i && armed_q) begin
        flag_d  = 1'b0;
        armed_d = 1'b0;
      end else if (stat_rd_i && flag_q) begin
        armed_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/brk_flag_guard.sv
module brk_flag_guard
  import brk_flag_pkg::*;
#(
  parameter int NUM_FLAGS  = 4,
  parameter int RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 halt_i,
  input  logic                 cfg_we_i,
  input  logic                 cfg_wdata_i,
  output logic                 cfg_rdata_o,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic                 stat_rd_i,
  input  logic [NUM_FLAGS-1:0] data_acc_i,
  output logic [NUM_FLAGS-1:0] flag_o,
  output logic                 halt_entry_o
);
  logic                 rst_s_n;
  halt_ctx_t            ctx;
  logic [NUM_FLAGS-1:0] armed;

  brk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  brk_halt_ctl u_ctl (
    .clk         (clk),
    .rst_s_n     (rst_s_n),
    .halt_i      (halt_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .clr_en_o    (cfg_rdata_o),
    .entry_o     (halt_entry_o),
    .ctx_o       (ctx)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    brk_flag_cell u_cell (
      .clk        (clk),
      .rst_s_n    (rst_s_n),
      .ctx_i      (ctx),
      .set_i      (set_i[g]),
      .stat_rd_i  (stat_rd_i),
      .data_acc_i (data_acc_i[g]),
      .flag_o     (flag_o[g]),
      .armed_o    (armed[g])
    );
  end
endmodule

// File: rtl/brk_flag_guard_chk.sv
module brk_flag_guard_chk #(
  parameter int NUM_FLAGS = 4
) (
  input logic                 clk,
  input logic                 rst_s_n,
  input logic                 halt_i,
  input logic                 cfg_we_i,
  input logic                 cfg_wdata_i,
  input logic                 cfg_rdata_o,
  input logic [NUM_FLAGS-1:0] set_i,
  input logic [NUM_FLAGS-1:0] data_acc_i,
  input logic [NUM_FLAGS-1:0] flag_o,
  input logic [NUM_FLAGS-1:0] armed,
  input logic                 halt_entry_o
);
  // R2
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));

  // R4
  guarded_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (halt_i && !cfg_rdata_o && !(|set_i)) |=> (flag_o == $past(flag_o) && armed == $past(armed)));

  // R10
  clear_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    1'b1 |=> (($past(flag_o) & ~flag_o & ~$past(data_acc_i)) == '0));

  // R7
  set_disarms_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|set_i) |=> ((armed & $past(set_i)) == '0));

  // R8
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    cfg_we_i |=> (cfg_rdata_o == $past(cfg_wdata_i)));

  // R9
  entry_rise_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (halt_i && !halt_entry_o && $past(!halt_i)) |=> halt_entry_o);

  // R9
  entry_single_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    halt_entry_o |=> !halt_entry_o);
endmodule

bind brk_flag_guard brk_flag_guard_chk #(.NUM_FLAGS(NUM_FLAGS)) u_chk (
  .clk          (clk),
  .rst_s_n      (rst_s_n),
  .halt_i       (halt_i),
  .cfg_we_i     (cfg_we_i),
  .cfg_wdata_i  (cfg_wdata_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .set_i        (set_i),
  .data_acc_i   (data_acc_i),
  .flag_o       (flag_o),
  .armed        (armed),
  .halt_entry_o (halt_entry_o)
);

// File: tb/tb_brk_flag_guard.sv
module tb_brk_flag_guard;
  localparam int N      = 4;
  localparam int CLK_PS = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         halt_i;
  logic         cfg_we_i;
  logic         cfg_wdata_i;
  logic         cfg_rdata_o;
  logic [N-1:0] set_i;
  logic         stat_rd_i;
  logic [N-1:0] data_acc_i;
  logic [N-1:0] flag_o;
  logic         halt_entry_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PS/2) clk = ~clk;

  brk_flag_guard #(.NUM_FLAGS(N)) dut (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .cfg_we_i(cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .set_i(set_i),
    .stat_rd_i(stat_rd_i), .data_acc_i(data_acc_i), .flag_o(flag_o),
    .halt_entry_o(halt_entry_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive for one cycle from a negedge; outputs are sampled at the next negedge
  task automatic pulse(input logic [N-1:0] s, input logic rd, input logic [N-1:0] acc);
    set_i = s; stat_rd_i = rd; data_acc_i = acc;
    @(negedge clk);
    set_i = '0; stat_rd_i = 1'b0; data_acc_i = '0;
  endtask

  task automatic write_en(input logic v);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk);
    cfg_we_i = 1'b0; cfg_wdata_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    halt_i = 1'b0; cfg_we_i = 1'b0; cfg_wdata_i = 1'b0;
    set_i = '0; stat_rd_i = 1'b0; data_acc_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PS * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 flags", flag_o, 0);
    check("R1 clr_en", cfg_rdata_o, 0);
    check("R1 entry", halt_entry_o, 0);

    // R8 readback
    write_en(1'b1); check("R8 write 1", cfg_rdata_o, 1);
    write_en(1'b0); check("R8 write 0", cfg_rdata_o, 0);

    // R2 set, R3 access without arming
    pulse(4'b0101, 1'b0, '0);
    check("R2 set", flag_o, 4'b0101);
    pulse('0, 1'b0, 4'b0001);
    check("R3 unarmed access", flag_o, 4'b0101);
    pulse('0, 1'b1, '0);
    pulse('0, 1'b0, 4'b0001);
    check("R3 two-step clear", flag_o, 4'b0100);

    // R7 set and access together, then no clear without new arm
    pulse('0, 1'b1, '0);
    pulse(4'b0100, 1'b0, 4'b0100);
    check("R7 set over clear", flag_o, 4'b0100);
    pulse('0, 1'b0, 4'b0100);
    check("R7 set disarms", flag_o, 4'b0100);

    // Sweep: clear-enable, arming before halt, status read inside halt
    for (int en = 0; en < 2; en++) begin
      for (int pre = 0; pre < 2; pre++) begin
        for (int inrd = 0; inrd < 2; inrd++) begin
          logic armed_at;
          logic exp1;
          logic exp2;
          do_reset();
          write_en(en[0]);
          pulse(4'b0011, 1'b0, '0);
          if (pre != 0) pulse('0, 1'b1, '0);
          halt_i = 1'b1;
          @(negedge clk);
          check("R9 entry pulse", halt_entry_o, 1);
          if (inrd != 0) pulse('0, 1'b1, '0);
          else @(negedge clk);
          check("R9 pulse ends", halt_entry_o, 0);
          pulse('0, 1'b0, 4'b0001);
          armed_at = pre[0] | (inrd[0] & en[0]);
          exp1 = !(en[0] & armed_at);
          // R4 guarded hold / R6 clear with enable
          check(en != 0 ? "R6 in-halt clear" : "R4 guarded hold", flag_o[0], exp1);
          halt_i = 1'b0;
          @(negedge clk);
          pulse('0, 1'b0, 4'b0001);
          exp2 = exp1 & !armed_at;
          // R5 arming survives, R6 stays cleared
          check("R5/R6 after halt", flag_o[0], exp2);
          check("R10 other flag", flag_o[1], 1);
          check("R10 idle flags", flag_o[3:2], 0);
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule